// File: doc/BRIEF.md
# Two-Level Lookahead 16-Bit Adder

This block adds two 16-bit unsigned operands and a carry-in in a single combinational path. It returns the 16-bit sum and the carry-out. The operands are split into four 4-bit groups. Each group computes its own three internal carries in sum-of-products form from its bit propagate and generate terms. Each group also produces one propagate term and one generate term for the whole group.

A second lookahead level takes the four group terms and the carry-in. From them it forms the carries entering groups 1, 2 and 3, and the final carry-out, each as one flat sum of products. No carry passes from group to group in a chain. Each sum bit is the bit propagate term XORed with the carry that enters that bit. The block has no clock and no state, so its outputs follow its inputs after the logic settles.

Top module: `cla16`

## Requirements
- R1: `sum` equals (`a` + `b` + `cin`) modulo 2^16 for every input combination.
- R2: `cout` is 1 exactly when `a` + `b` + `cin` is 2^16 or more, and 0 otherwise.
- R3: The carry that enters bit 4k (k = 1, 2, 3) equals the carry out of the low 4k bits of `a` + `b` + `cin`. For example, 0x000F + 0x0001 gives 0x0010, and 0x0FFF + 0x0001 gives 0x1000.
- R4: When every bit position propagates, `cin` reaches `cout` through all four groups. 0xFFFF + 0x0000 + 1 gives sum 0x0000 and cout 1, and with `cin` = 0 it gives 0xFFFF and cout 0.
- R5: A group whose top bit generates forces its outgoing carry even when nothing below it carries. 0x8000 + 0x8000 gives 0x0000 and cout 1, and 0x0080 + 0x0080 gives 0x0100.
- R6: With alternating patterns, 0xAAAA + 0x5555 gives 0xFFFF and cout 0. With `cin` = 1 the same operands give 0x0000 and cout 1.
- R7: A carry made inside one group reaches the higher bits of that group. 0x0007 + 0x0001 gives 0x0008, and 0x0003 + 0x0001 + 1 gives 0x0005.
- R8: All-zero inputs give sum 0x0000 and cout 0. 0xFFFF + 0xFFFF + 1 gives 0xFFFF and cout 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 15 |

## Verification
The hardest case to reach from the ports is a long propagate run that crosses group boundaries. In that case the second lookahead level has to chain every group propagate term through to its output. Random operands almost never propagate in all 16 bits, or across a whole group boundary. The stimulus therefore adds directed vectors built around these runs: all-ones plus a carry-in, a full low group plus one, and alternating patterns that propagate in every bit. It also includes operands that generate only in a group's top bit, so that the group generate term alone sets the outgoing carry.

// File: rtl/cla16.sv
module cla16 #(
  parameter int W  = 16,
  parameter int GW = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int NG = W / GW;

  logic [W-1:0]  bp;
  logic [W-1:0]  bg;
  logic [NG-1:0] grp_p;
  logic [NG-1:0] grp_g;
  logic [NG:0]   grp_c;

  assign bp = a ^ b;
  assign bg = a & b;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    logic [GW-1:0] lp, lg;
    logic [GW-1:0] lc;
    logic          gp, gg;

    assign lp = bp[k*GW +: GW];
    assign lg = bg[k*GW +: GW];

    always_comb begin
      lc[0] = grp_c[k];
      for (int i = 1; i < GW; i++) begin
        logic acc, term;
        term = grp_c[k];
        for (int m = 0; m < i; m++) term = term & lp[m];
        acc = term;
        for (int j = 0; j < i; j++) begin
          term = lg[j];
          for (int m = j + 1; m < i; m++) term = term & lp[m];
          acc = acc | term;
        end
        lc[i] = acc;
      end
    end

    always_comb begin
      gp = &lp;
      gg = 1'b0;
      for (int j = 0; j < GW; j++) begin
        logic term;
        term = lg[j];
        for (int m = j + 1; m < GW; m++) term = term & lp[m];
        gg = gg | term;
      end
    end

    assign grp_p[k] = gp;
    assign grp_g[k] = gg;
    assign sum[k*GW +: GW] = lp ^ lc;
  end

  always_comb begin
    grp_c[0] = cin;
    for (int k = 1; k <= NG; k++) begin
      logic acc, term;
      term = cin;
      for (int m = 0; m < k; m++) term = term & grp_p[m];
      acc = term;
      for (int j = 0; j < k; j++) begin
        term = grp_g[j];
        for (int m = j + 1; m < k; m++) term = term & grp_p[m];
        acc = acc | term;
      end
      grp_c[k] = acc;
    end
  end

  assign cout = grp_c[NG];
endmodule

// File: rtl/cla16_chk.sv
module cla16_chk #(
  parameter int W  = 16,
  parameter int GW = 4,
  localparam int NG = W / GW
) (
  input logic [W-1:0]  a,
  input logic [W-1:0]  b,
  input logic          cin,
  input logic [W-1:0]  sum,
  input logic          cout,
  input logic [NG-1:0] grp_p,
  input logic [NG-1:0] grp_g,
  input logic [NG:0]   grp_c
);
  logic [W:0] full;
  assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

  always_comb begin
    // R1
    sum_chk: assert (sum == full[W-1:0]);
    // R2
    cout_chk: assert (cout == full[W]);
    for (int k = 1; k < NG; k++) begin
      logic [W:0] mask, part;
      mask = ({{W{1'b0}}, 1'b1} << (k*GW)) - 1'b1;
      part = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {{W{1'b0}}, cin};
      // R3
      grp_carry_chk: assert (grp_c[k] == part[k*GW]);
    end
    for (int k = 0; k < NG; k++) begin
      // R4
      grp_prop_chk: assert (!grp_p[k] || (grp_c[k+1] == grp_c[k]));
      // R5
      grp_gen_chk: assert (!grp_g[k] || grp_c[k+1]);
    end
  end
endmodule

bind cla16 cla16_chk #(.W(W), .GW(GW)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .grp_p(grp_p), .grp_g(grp_g), .grp_c(grp_c)
);

// File: tb/cla16_tb.sv
module cla16_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int checks = 0;
  int fails  = 0;
  logic [W:0] expq[$];
  string      tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cla16 u_dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb,
                       input logic vc, input string tag);
    logic [W:0] exp_v;
    integer tot;
    @(negedge clk);
    a = va; b = vb; cin = vc;
    tot = int'(va) + int'(vb) + int'(vc);
    exp_v = tot[W:0];
    expq.push_back(exp_v);
    tagq.push_back(tag);
    @(posedge clk);
    #1;
    begin
      logic [W:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      checks++;
      if ({cout, sum} !== e) begin
        fails++;
        $display("FAIL %s: a=%h b=%h cin=%b got cout=%b sum=%h expected cout=%b sum=%h",
                 t, va, vb, vc, cout, sum, e[W], e[W-1:0]);
      end
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    apply(16'h0000, 16'h0000, 1'b0, "R8 zero");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R8 max");
    apply(16'h000F, 16'h0001, 1'b0, "R3 c4");
    apply(16'h00FF, 16'h0001, 1'b0, "R3 c8");
    apply(16'h0FFF, 16'h0001, 1'b0, "R3 c12");
    apply(16'h0000, 16'h000F, 1'b1, "R3 c4 via cin");
    apply(16'hFFFF, 16'h0000, 1'b1, "R4 full propagate");
    apply(16'hFFFF, 16'h0000, 1'b0, "R4 propagate no cin");
    apply(16'h8000, 16'h8000, 1'b0, "R5 top generate");
    apply(16'h0080, 16'h0080, 1'b0, "R5 group generate");
    apply(16'hAAAA, 16'h5555, 1'b0, "R6 alternating");
    apply(16'hAAAA, 16'h5555, 1'b1, "R6 alternating cin");
    apply(16'h5555, 16'hAAAA, 1'b1, "R6 alternating swap");
    apply(16'h0007, 16'h0001, 1'b0, "R7 in-group");
    apply(16'h0003, 16'h0001, 1'b1, "R7 in-group cin");
    for (int i = 0; i < 3000; i++)
      apply(W'($urandom), W'($urandom), 1'($urandom), "R1 R2 random");
    for (int i = 0; i < W; i++) begin
      apply(16'hFFFF >> i, 16'h0001, 1'b0, "R3 R4 run");
      apply(16'h0001 << i, 16'h0001 << i, 1'b1, "R5 single generate");
    end
    finish_run();
  end
endmodule